// File: doc/BRIEF.md
# Flash Page-Write Buffer Controller

This block sits between a small register bus and a behavioural model of an on-chip flash array. Software first sets a byte pointer and then pushes data bytes through a one-byte data port. Each push loads one holding register of a write-block-sized buffer and advances the pointer. The array itself is not touched by these pushes. A long operation starts only after a two-key unlock and a start request with a valid control word. The operation is either a block program, which ANDs the buffer into the addressed write block, or a block erase, which sets a 64-byte erase block to FFh. While it runs, the block holds its stall output high for a fixed number of clock cycles. The CPU is frozen for that time and bus writes are ignored.

Control is a three-state machine. `S_IDLE` accepts bus traffic. The transition *launch-program* or *launch-erase* fires on an accepted start and moves to `S_PROG` or `S_ERASE`. The transition *timer-expire* fires in the last cycle of the count. It commits the array change, refills every holding register with FFh and returns to `S_IDLE`. A separate key tracker has the states `U_LOCKED`, `U_HALF` (first key seen) and `U_ARMED` (both keys seen, in order). A start attempt of any kind consumes the armed state.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `stall` is 0 and the pointer bytes (addresses 0 and 1) read 00h. The control word (address 3) reads 00h. Every holding register holds FFh, so a program run issued without loads leaves the block unchanged.
- R2: A write to the data port (address 2) loads the holding register selected by the pointer's low log2(WB) bits and then increments the pointer. It leaves the array unchanged, as read back through address 2, which returns the array byte at the pointer.
- R3: A control write (address 3) with bit0 (start) set is accepted only when the tracker is armed, bit1 (write enable) is 1, bit2 (program-memory select) is 1 and bit3 (configuration select) is 0. A rejected request changes neither the array nor `stall`, and it sets the error flag (control bit5). An accepted request clears that flag.
- R4: The unlock is armed only by writing 55h and then AAh to the key register (address 4). Any other value at either step returns the tracker to locked.
- R5: After an accepted start, `stall` is high for exactly PROG_CYCLES cycles. The start bit reads 1 while busy and 0 afterwards.
- R6: A program run sets each byte of the target write block to its old value AND the matching holding register, so FFh leaves a byte unchanged and no bit is set.
- R7: All holding registers return to FFh after every completed operation.
- R8: The pointer value at the moment of the start selects the block, aligned down to WB bytes for a program run (control bit4 = 0) and to 64 bytes for an erase.
- R9: An erase (control bit4 = 1) sets all 64 bytes of the selected erase block to FFh and leaves its neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select: 0 ptr low, 1 ptr high, 2 data port, 3 control, 4 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| stall | output | 1 | High while a long operation runs |

## Verification
The embedded properties are checked on every cycle. They cover the following: a busy period begins only from an armed tracker, the timer never passes its limit, and a busy period ends exactly at the terminal count. They also cover arming only after the ordered key pair, the buffer being all-ones after each commit, and the array bytes staying stable outside commits and only clearing bits during a program run. The directed scenarios are what show the data-dependent results. These are the AND-merge values, the choice of the target block from the pointer's upper bits, the exact erase boundaries, the pointer increment, and that rejected starts leave the loaded buffer and the array intact.

// File: rtl/flash_pc_pkg.sv
package flash_pc_pkg;
    localparam logic [2:0] A_PTR_LO = 3'd0;
    localparam logic [2:0] A_PTR_HI = 3'd1;
    localparam logic [2:0] A_DATA   = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_KEY    = 3'd4;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PROG  = 2'd1,
        S_ERASE = 2'd2
    } op_state_e;

    typedef enum logic [1:0] {
        U_LOCKED = 2'd0,
        U_HALF   = 2'd1,
        U_ARMED  = 2'd2
    } key_state_e;
endpackage

// File: rtl/flash_unlock.sv
module flash_unlock
    import flash_pc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       consume,
    output logic       armed
);
    key_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= U_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (consume) begin
            st_d = U_LOCKED;
        end else if (key_wr) begin
            unique case (st_q)
                U_LOCKED: st_d = (key_data == KEY_FIRST)  ? U_HALF  : U_LOCKED;
                U_HALF:   st_d = (key_data == KEY_SECOND) ? U_ARMED : U_LOCKED;
                U_ARMED:  st_d = (key_data == KEY_FIRST)  ? U_HALF  : U_LOCKED;
                default:  st_d = U_LOCKED;
            endcase
        end
    end

    assign armed = (st_q == U_ARMED);

    // R4: arming only follows the second key written while half unlocked
    p_arm_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(key_wr && key_data == KEY_SECOND && st_q == U_HALF));
endmodule

// File: rtl/flash_hold_bank.sv
module flash_hold_bank #(
    parameter int WB = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [$clog2(WB)-1:0] ld_idx,
    input  logic [7:0]        ld_data,
    input  logic              clr,
    output logic [WB*8-1:0]   hold_flat
);
    logic [7:0] hold_q [WB];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < WB; i++) hold_q[i] <= 8'hFF;
        end else if (ld) begin
            hold_q[ld_idx] <= ld_data;
        end
    end

    for (genvar g = 0; g < WB; g++) begin : g_flat
        assign hold_flat[g*8 +: 8] = hold_q[g];
    end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
    parameter int ARRAY_BYTES = 512,
    parameter int WB          = 32,
    parameter int EB          = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           do_prog,
    input  logic                           do_erase,
    input  logic [$clog2(ARRAY_BYTES)-1:0] op_addr,
    input  logic [WB*8-1:0]                hold_flat,
    input  logic [$clog2(ARRAY_BYTES)-1:0] rd_addr,
    output logic [7:0]                     rd_data
);
    localparam int AW  = $clog2(ARRAY_BYTES);
    localparam int WIW = $clog2(WB);
    localparam int EIW = $clog2(EB);

    logic [7:0]    mem [ARRAY_BYTES];
    logic [AW-1:0] pbase, ebase;

    assign pbase = {op_addr[AW-1:WIW], WIW'(0)};
    assign ebase = {op_addr[AW-1:EIW], EIW'(0)};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'h00;
        end else if (do_erase) begin
            for (int i = 0; i < EB; i++) mem[ebase | AW'(i)] <= 8'hFF;
        end else if (do_prog) begin
            for (int i = 0; i < WB; i++)
                mem[pbase | AW'(i)] <= mem[pbase | AW'(i)] & hold_flat[i*8 +: 8];
        end
    end

    assign rd_data = mem[rd_addr];

    // R2: outside a commit the observed byte does not move
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_prog && !do_erase) |=> ($stable(rd_addr) -> $stable(rd_data)));
    // R6: a program commit never turns a 0 bit into a 1
    p_prog_clears_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_prog && !do_erase) |=> ($stable(rd_addr) -> ((rd_data & ~$past(rd_data)) == 8'h00)));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_pc_pkg::*;
#(
    parameter int ARRAY_BYTES = 512,
    parameter int WB          = 32,
    parameter int EB          = 64,
    parameter int PROG_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       stall
);
    localparam int AW = $clog2(ARRAY_BYTES);
    localparam int IW = $clog2(WB);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    op_state_e     state_q, state_d;
    logic [TW-1:0] timer_q;
    logic [AW-1:0] ptr_q, op_addr_q;
    logic          wren_q, memsel_q, cfg_q, erase_q, err_q;
    logic          armed, wr_en, start_req, start_ok, tbl_wr, key_wr;
    logic          tmr_last, do_prog, do_erase, hold_clr;
    logic [WB*8-1:0] hold_flat;
    logic [7:0]    arr_rd;

    assign wr_en     = bus_wr && (state_q == S_IDLE);
    assign start_req = wr_en && (bus_addr == A_CTRL) && bus_wdata[0];
    assign start_ok  = start_req && armed && bus_wdata[1] && bus_wdata[2] && !bus_wdata[3];
    assign tbl_wr    = wr_en && (bus_addr == A_DATA);
    assign key_wr    = wr_en && (bus_addr == A_KEY);
    assign tmr_last  = (timer_q == TW'(PROG_CYCLES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        do_prog  = 1'b0;
        do_erase = 1'b0;
        hold_clr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_ok) state_d = bus_wdata[4] ? S_ERASE : S_PROG;
            end
            S_PROG: begin
                if (tmr_last) begin
                    do_prog  = 1'b1;
                    hold_clr = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_ERASE: begin
                if (tmr_last) begin
                    do_erase = 1'b1;
                    hold_clr = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign stall = (state_q != S_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q   <= '0;
            ptr_q     <= '0;
            op_addr_q <= '0;
            wren_q    <= 1'b0;
            memsel_q  <= 1'b0;
            cfg_q     <= 1'b0;
            erase_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            timer_q <= (state_q == S_IDLE || tmr_last) ? '0 : timer_q + 1'b1;
            if (wr_en) begin
                unique case (bus_addr)
                    A_PTR_LO: ptr_q <= {ptr_q[AW-1:8], bus_wdata};
                    A_PTR_HI: ptr_q <= AW'({bus_wdata, ptr_q[7:0]});
                    A_DATA:   ptr_q <= ptr_q + 1'b1;
                    A_CTRL: begin
                        wren_q   <= bus_wdata[1];
                        memsel_q <= bus_wdata[2];
                        cfg_q    <= bus_wdata[3];
                        erase_q  <= bus_wdata[4];
                        if (start_ok)       err_q <= 1'b0;
                        else if (start_req) err_q <= 1'b1;
                        if (start_ok)       op_addr_q <= ptr_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_PTR_LO: bus_rdata = ptr_q[7:0];
            A_PTR_HI: bus_rdata = 8'(ptr_q >> 8);
            A_DATA:   bus_rdata = arr_rd;
            A_CTRL:   bus_rdata = {2'b00, err_q, erase_q, cfg_q, memsel_q, wren_q, stall};
            default:  bus_rdata = 8'h00;
        endcase
    end

    flash_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(bus_wdata),
        .consume(start_req), .armed(armed)
    );

    flash_hold_bank #(.WB(WB)) u_hold (
        .clk(clk), .rst_n(rst_n), .ld(tbl_wr), .ld_idx(ptr_q[IW-1:0]),
        .ld_data(bus_wdata), .clr(hold_clr), .hold_flat(hold_flat)
    );

    flash_array_model #(.ARRAY_BYTES(ARRAY_BYTES), .WB(WB), .EB(EB)) u_array (
        .clk(clk), .rst_n(rst_n), .do_prog(do_prog), .do_erase(do_erase),
        .op_addr(op_addr_q), .hold_flat(hold_flat), .rd_addr(ptr_q), .rd_data(arr_rd)
    );

    // R3: a busy period only begins from an armed tracker
    p_start_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(armed));
    // R5: timer stays inside its window while busy
    p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (timer_q < TW'(PROG_CYCLES)));
    // R5: busy ends exactly after the terminal count
    p_stall_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> ($past(timer_q) == TW'(PROG_CYCLES - 1)));
    // R7: buffer is all ones after each commit
    p_hold_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (hold_flat == '1));
endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int ARRAY_BYTES = 512;
    localparam int WB          = 32;
    localparam int EB          = 64;
    localparam int PROG_CYCLES = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stall;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [ARRAY_BYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_ctrl #(.ARRAY_BYTES(ARRAY_BYTES), .WB(WB), .EB(EB), .PROG_CYCLES(PROG_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall(stall)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_ptr(input int p);
        bus_write(3'd0, 8'(p));
        bus_write(3'd1, 8'(p >> 8));
    endtask

    task automatic unlock();
        bus_write(3'd4, 8'h55);
        bus_write(3'd4, 8'hAA);
    endtask

    task automatic run_op(input logic [7:0] ctl, output int cycles);
        cycles = 0;
        bus_write(3'd3, ctl);
        while (stall && cycles < 1000) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic check_range(input string req, input int base, input int len);
        logic [7:0] d;
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            set_ptr(base + i);
            bus_read(3'd2, d);
            if (d != exp_mem[base + i]) begin
                bad++;
                if (bad == 1) check(req, d, exp_mem[base + i]);
            end
        end
        if (bad == 0) check(req, 0, 0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 stall", stall, 0);
        bus_read(3'd0, d); check("R1 ptr lo", d, 0);
        bus_read(3'd1, d); check("R1 ptr hi", d, 0);
        bus_read(3'd3, d); check("R1 ctrl", d, 0);
    endtask

    task automatic t_table_load();
        logic [7:0] d;
        set_ptr(9'h040);
        for (int i = 0; i < 4; i++) bus_write(3'd2, 8'(8'h10 + i));
        bus_read(3'd0, d); check("R2 ptr increment", d, 8'h44);
        set_ptr(9'h040);
        bus_read(3'd2, d); check("R2 array untouched", d, 8'h00);
    endtask

    task automatic t_erase();
        int cyc;
        logic [7:0] d;
        set_ptr(9'h05A);
        unlock();
        run_op(8'h17, cyc);
        check("R5 stall length", cyc, PROG_CYCLES);
        bus_read(3'd3, d); check("R5 start self-clears", int'(d[0]), 0);
        for (int i = 0; i < EB; i++) exp_mem[9'h040 + i] = 8'hFF;
        check_range("R9 erase block", 9'h03F, EB + 2);
    endtask

    task automatic t_empty_prog();
        int cyc;
        set_ptr(9'h040);
        unlock();
        run_op(8'h07, cyc);
        check("R1 R7 stall", cyc, PROG_CYCLES);
        check_range("R7 buffer refilled, block unchanged", 9'h040, WB);
    endtask

    task automatic t_program();
        int cyc;
        set_ptr(9'h040);
        for (int i = 0; i < WB; i++) begin
            logic [7:0] v = (i % 4 == 0) ? 8'hFF : 8'(8'hA5 ^ (i * 7));
            bus_write(3'd2, v);
            exp_mem[9'h040 + i] = exp_mem[9'h040 + i] & v;
        end
        set_ptr(9'h045);
        unlock();
        run_op(8'h07, cyc);
        check_range("R6 program AND", 9'h040, WB);
        set_ptr(9'h040);
        bus_write(3'd2, 8'hF0);
        exp_mem[9'h040] = exp_mem[9'h040] & 8'hF0;
        set_ptr(9'h040);
        unlock();
        run_op(8'h07, cyc);
        check_range("R6 FF keeps bytes", 9'h040, WB);
    endtask

    task automatic t_block_select();
        int cyc;
        set_ptr(9'h080);
        unlock();
        run_op(8'h17, cyc);
        for (int i = 0; i < EB; i++) exp_mem[9'h080 + i] = 8'hFF;
        set_ptr(9'h020);
        for (int i = 0; i < WB; i++) begin
            bus_write(3'd2, 8'(8'h3C + i));
            exp_mem[9'h080 + i] = 8'(8'h3C + i);
        end
        set_ptr(9'h09A);
        unlock();
        run_op(8'h07, cyc);
        check_range("R8 target block", 9'h080, WB);
        check_range("R8 loading block untouched", 9'h020, WB);
    endtask

    task automatic t_bad_unlock();
        int cyc;
        logic [7:0] d;
        set_ptr(9'h0C0);
        unlock();
        run_op(8'h17, cyc);
        for (int i = 0; i < EB; i++) exp_mem[9'h0C0 + i] = 8'hFF;
        set_ptr(9'h0C0);
        bus_write(3'd2, 8'h12);
        // broken key order
        bus_write(3'd4, 8'h55); bus_write(3'd4, 8'h00); bus_write(3'd4, 8'hAA);
        run_op(8'h07, cyc);
        check("R4 broken order rejected", cyc, 0);
        bus_read(3'd3, d); check("R3 error flag", int'(d[5]), 1);
        // missing write enable
        unlock();
        run_op(8'h05, cyc); check("R3 no wren rejected", cyc, 0);
        // configuration select set
        unlock();
        run_op(8'h0F, cyc); check("R3 cfg select rejected", cyc, 0);
        // start without unlock
        run_op(8'h07, cyc); check("R3 no unlock rejected", cyc, 0);
        check_range("R3 array unchanged", 9'h0C0, 2);
        set_ptr(9'h0C0);
        unlock();
        run_op(8'h07, cyc); check("R3 valid start", cyc, PROG_CYCLES);
        bus_read(3'd3, d); check("R3 error cleared", int'(d[5]), 0);
        exp_mem[9'h0C0] = 8'h12;
        check_range("R3 buffer kept through rejects", 9'h0C0, 2);
    endtask

    initial begin
        for (int i = 0; i < ARRAY_BYTES; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table_load();
        t_erase();
        t_empty_prog();
        t_program();
        t_block_select();
        t_bad_unlock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule